// File: doc/BRIEF.md
# Calibrated Real-Time Clock Controller

This block keeps wall time as a 32-bit count of seconds. A slow crystal tick arrives as a single-cycle enable on the system clock. A prescaler counts these ticks. When its count reaches a programmable limit, it emits a one-second event and starts again from zero. Each event advances the seconds counter. The counter is also compared with an alarm value. Software does all calendar arithmetic and sees only the raw second count.

Long-term drift is trimmed by a fractional correction that works over a window of sixteen seconds. The first N seconds of each window, where N is the fraction field, take one extra tick. Two interrupt sources exist: a per-second event and an alarm match. Each source has a sticky status bit and a mask bit. A single-cycle 32-bit register port gives access to everything. Writes complete on the clock edge, and read data appears on the cycle after the read strobe.

Top module: `rtc_ctrl`

## Requirements
- R1: After reset, the registers hold these values: seconds 0, tick 0, set-time readback 0, alarm 0, interrupt status 0, interrupt mask 0, calibration 0x198233, and control bit 24 set. Both interrupt outputs are low.
- R2: A write to byte offset 0x00 loads the seconds counter and clears the tick counter and the correction window. Offset 0x04 returns the last value written to 0x00. Offset 0x10 returns the running seconds count.
- R3: Each one-second event increments the seconds counter by exactly one, and 0xFFFFFFFF wraps to 0.
- R4: With calibration bit 20 clear, one second lasts (bits 15:0) + 1 ticks. Offset 0x14 returns the current sub-second tick count.
- R5: With calibration bit 20 set and fraction value N in bits 19:16, the first N seconds of each sixteen-second window last (bits 15:0) + 2 ticks. The rest last (bits 15:0) + 1 ticks.
- R6: A write to offset 0x08 stores bits 20:0 and ignores bits 31:21. Offset 0x0C returns the stored 21-bit word.
- R7: While control bit 24 (offset 0x40) is clear, the tick and seconds counters hold their values.
- R8: Status bit 0 sets on every one-second event. Status bit 1 sets on the event at which the incremented count equals the alarm register (offset 0x18, read/write).
- R9: Writing 1 to a bit of the status register (offset 0x20) clears that bit. Bits written as 0 are unchanged.
- R10: Writing 1 to bit k of offset 0x28 sets mask bit k. Writing 1 to bit k of offset 0x2C clears it. Bits written as 0 have no effect. Offset 0x24 reads the mask, where 1 means enabled.
- R11: `irq_sec` is high exactly while status bit 0 and mask bit 0 are both set. `irq_alarm` does the same for bit 1.
- R12: A read of the enable or disable register, or of an unmapped offset, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle crystal tick enable |
| reg_addr | input | ADDR_W | Byte address of the register port |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; data valid next cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| irq_sec | output | 1 | Per-second interrupt, level |
| irq_alarm | output | 1 | Alarm interrupt, level |

## Verification
The bench uses the default parameters: a 7-bit address, a 16-bit tick field, a 4-bit fraction and the 0x198233 reset calibration. It checks the reset calibration directly. It then reprograms the tick maximum to 3 at run time, so one second takes only four or five crystal ticks. The bench drives those ticks one at a time, which lets it count exact second boundaries. It walks a full sixteen-second correction window and the start of the next one. It reaches the 32-bit wrap by loading a count just below the maximum.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DATA_W  = 32;
    localparam int IRQ_N   = 2;
    localparam int IRQ_SEC = 0;
    localparam int IRQ_ALM = 1;
    localparam int OSC_BIT = 24;

    // byte offsets of the register map
    localparam int unsigned OFS_TIME_LD  = 'h00;
    localparam int unsigned OFS_TIME_RB  = 'h04;
    localparam int unsigned OFS_CAL_LD   = 'h08;
    localparam int unsigned OFS_CAL_RB   = 'h0C;
    localparam int unsigned OFS_SECS     = 'h10;
    localparam int unsigned OFS_TICK     = 'h14;
    localparam int unsigned OFS_ALARM    = 'h18;
    localparam int unsigned OFS_STATUS   = 'h20;
    localparam int unsigned OFS_MASK     = 'h24;
    localparam int unsigned OFS_UNMASK   = 'h28;
    localparam int unsigned OFS_REMASK   = 'h2C;
    localparam int unsigned OFS_CTRL     = 'h40;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICK_W = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              clear,
    input  logic [TICK_W-1:0] tick_max,
    input  logic [FRAC_W-1:0] frac,
    input  logic              frac_en,
    output logic [TICK_W:0]   tick_cnt,
    output logic              sec_evt
);
    localparam int CW = TICK_W + 1;

    typedef struct packed {
        logic [CW-1:0]     tick;
        logic [FRAC_W-1:0] win;
    } ps_s;

    ps_s d, q;
    logic          stretch;
    logic [CW-1:0] limit;
    logic          hit;

    always_comb begin
        stretch = frac_en && (q.win < frac);
        limit   = {1'b0, tick_max} + CW'(stretch);
        hit     = tick_in && !clear && (q.tick >= limit);
        d       = q;
        if (clear) begin
            d = '0;
        end else if (hit) begin
            d.tick = '0;
            d.win  = q.win + FRAC_W'(1);
        end else if (tick_in) begin
            d.tick = q.tick + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_cnt = q.tick;
    assign sec_evt  = hit;
endmodule

// File: rtl/rtc_irq_bank.sv
module rtc_irq_bank #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_evt,
    input  logic [N_SRC-1:0] clr_w1,
    input  logic [N_SRC-1:0] en_w1,
    input  logic [N_SRC-1:0] dis_w1,
    output logic [N_SRC-1:0] status,
    output logic [N_SRC-1:0] mask,
    output logic [N_SRC-1:0] irq
);
    typedef struct packed {
        logic [N_SRC-1:0] sts;
        logic [N_SRC-1:0] msk;
    } ib_s;

    ib_s d, q;

    always_comb begin
        d     = q;
        d.sts = (q.sts & ~clr_w1) | set_evt;
        d.msk = (q.msk | en_w1) & ~dis_w1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_line
        assign irq[g] = q.sts[g] & q.msk[g];
    end

    assign status = q.sts;
    assign mask   = q.msk;
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
    import rtc_pkg::*;
#(
    parameter int          ADDR_W    = 7,
    parameter int          TICK_W    = 16,
    parameter int          FRAC_W    = 4,
    parameter logic [31:0] CAL_RESET = 32'h0019_8233
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_sec,
    output logic              irq_alarm
);
    localparam int WORD_W  = ADDR_W - 2;
    localparam int CAL_W   = TICK_W + FRAC_W + 1;
    localparam int FEN_BIT = TICK_W + FRAC_W;

    localparam logic [WORD_W-1:0] W_TIME_LD = WORD_W'(OFS_TIME_LD >> 2);
    localparam logic [WORD_W-1:0] W_TIME_RB = WORD_W'(OFS_TIME_RB >> 2);
    localparam logic [WORD_W-1:0] W_CAL_LD  = WORD_W'(OFS_CAL_LD >> 2);
    localparam logic [WORD_W-1:0] W_CAL_RB  = WORD_W'(OFS_CAL_RB >> 2);
    localparam logic [WORD_W-1:0] W_SECS    = WORD_W'(OFS_SECS >> 2);
    localparam logic [WORD_W-1:0] W_TICK    = WORD_W'(OFS_TICK >> 2);
    localparam logic [WORD_W-1:0] W_ALARM   = WORD_W'(OFS_ALARM >> 2);
    localparam logic [WORD_W-1:0] W_STATUS  = WORD_W'(OFS_STATUS >> 2);
    localparam logic [WORD_W-1:0] W_MASK    = WORD_W'(OFS_MASK >> 2);
    localparam logic [WORD_W-1:0] W_UNMASK  = WORD_W'(OFS_UNMASK >> 2);
    localparam logic [WORD_W-1:0] W_REMASK  = WORD_W'(OFS_REMASK >> 2);
    localparam logic [WORD_W-1:0] W_CTRL    = WORD_W'(OFS_CTRL >> 2);

    typedef struct packed {
        logic [DATA_W-1:0] secs;
        logic [DATA_W-1:0] shadow;
        logic [DATA_W-1:0] alarm;
        logic [DATA_W-1:0] rdata;
        logic [CAL_W-1:0]  cal;
        logic              osc_en;
    } top_s;

    top_s d, q;

    logic [WORD_W-1:0] word;
    logic [1:0]        unused_byte_lane;
    logic              wr_time, wr_cal, wr_alarm, wr_sts, wr_en, wr_dis, wr_ctrl;
    logic [TICK_W:0]   tick_cnt;
    logic              sec_evt;
    logic              alarm_hit;
    logic [IRQ_N-1:0]  set_evt, clr_w1, en_w1, dis_w1;
    logic [IRQ_N-1:0]  status, mask, irq;

    assign word             = reg_addr[ADDR_W-1:2];
    assign unused_byte_lane = reg_addr[1:0];

    assign wr_time  = reg_wr && (word == W_TIME_LD);
    assign wr_cal   = reg_wr && (word == W_CAL_LD);
    assign wr_alarm = reg_wr && (word == W_ALARM);
    assign wr_sts   = reg_wr && (word == W_STATUS);
    assign wr_en    = reg_wr && (word == W_UNMASK);
    assign wr_dis   = reg_wr && (word == W_REMASK);
    assign wr_ctrl  = reg_wr && (word == W_CTRL);

    rtc_prescaler #(
        .TICK_W (TICK_W),
        .FRAC_W (FRAC_W)
    ) i_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_en && q.osc_en),
        .clear    (wr_time),
        .tick_max (q.cal[TICK_W-1:0]),
        .frac     (q.cal[FEN_BIT-1:TICK_W]),
        .frac_en  (q.cal[FEN_BIT]),
        .tick_cnt (tick_cnt),
        .sec_evt  (sec_evt)
    );

    assign alarm_hit = sec_evt && ((q.secs + DATA_W'(1)) == q.alarm);

    always_comb begin
        set_evt          = '0;
        set_evt[IRQ_SEC] = sec_evt;
        set_evt[IRQ_ALM] = alarm_hit;
        clr_w1           = wr_sts ? reg_wdata[IRQ_N-1:0] : '0;
        en_w1            = wr_en  ? reg_wdata[IRQ_N-1:0] : '0;
        dis_w1           = wr_dis ? reg_wdata[IRQ_N-1:0] : '0;
    end

    rtc_irq_bank #(
        .N_SRC (IRQ_N)
    ) i_irq_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr_w1  (clr_w1),
        .en_w1   (en_w1),
        .dis_w1  (dis_w1),
        .status  (status),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        d = q;
        if (wr_time) begin
            d.secs   = reg_wdata;
            d.shadow = reg_wdata;
        end else if (sec_evt) begin
            d.secs = q.secs + DATA_W'(1);
        end
        if (wr_cal)   d.cal    = reg_wdata[CAL_W-1:0];
        if (wr_alarm) d.alarm  = reg_wdata;
        if (wr_ctrl)  d.osc_en = reg_wdata[OSC_BIT];
        if (reg_rd) begin
            case (word)
                W_TIME_RB: d.rdata = q.shadow;
                W_CAL_RB:  d.rdata = DATA_W'(q.cal);
                W_SECS:    d.rdata = q.secs;
                W_TICK:    d.rdata = DATA_W'(tick_cnt[TICK_W-1:0]);
                W_ALARM:   d.rdata = q.alarm;
                W_STATUS:  d.rdata = DATA_W'(status);
                W_MASK:    d.rdata = DATA_W'(mask);
                W_CTRL:    d.rdata = DATA_W'(q.osc_en) << OSC_BIT;
                default:   d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.cal    <= CAL_RESET[CAL_W-1:0];
            q.osc_en <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign reg_rdata = q.rdata;
    assign irq_sec   = irq[IRQ_SEC];
    assign irq_alarm = irq[IRQ_ALM];
endmodule

// File: rtl/rtc_ctrl_chk.sv
module rtc_ctrl_chk #(
    parameter int ADDR_W = 7,
    parameter int TICK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       secs,
    input logic [31:0]       alarm,
    input logic              osc_en,
    input logic [TICK_W:0]   tick,
    input logic [1:0]        status,
    input logic [1:0]        mask,
    input logic              irq_sec,
    input logic              irq_alarm
);
    localparam int WORD_W = ADDR_W - 2;
    logic [WORD_W-1:0] word;
    logic              ld, sts_clr0, en0;
    assign word     = reg_addr[ADDR_W-1:2];
    assign ld       = reg_wr && (word == WORD_W'(0));
    assign sts_clr0 = reg_wr && (word == WORD_W'(8)) && reg_wdata[0];
    assign en0      = reg_wr && (word == WORD_W'(10)) && reg_wdata[0];

    AST_LOAD_SECS: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (secs == $past(reg_wdata)) && (tick == '0)); // R2
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((secs != $past(secs)) && !$past(ld)) |-> (secs == $past(secs) + 32'd1)); // R3
    AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !ld) |=> ($stable(secs) && $stable(tick))); // R7
    AST_ALARM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> (secs == $past(alarm))); // R8
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !sts_clr0) |=> status[0]); // R9
    AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        en0 |=> mask[0]); // R10
    AST_SEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sec |-> (mask[0] && status[0])); // R11
    AST_ALM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_alarm |-> (mask[1] && status[1])); // R11
endmodule

bind rtc_ctrl rtc_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .TICK_W (TICK_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .secs      (q.secs),
    .alarm     (q.alarm),
    .osc_en    (q.osc_en),
    .tick      (tick_cnt),
    .status    (status),
    .mask      (mask),
    .irq_sec   (irq_sec),
    .irq_alarm (irq_alarm)
);

// File: tb/test_rtc_ctrl.sv
module test_rtc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_sec, irq_alarm;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    rtc_ctrl i_rtc_ctrl (
        .clk, .rst_n, .tick_en, .reg_addr, .reg_wr, .reg_rd,
        .reg_wdata, .reg_rdata, .irq_sec, .irq_alarm
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 secs", 7'h10, 32'd0);
        rd_chk("R1 tick", 7'h14, 32'd0);
        rd_chk("R1 time readback", 7'h04, 32'd0);
        rd_chk("R1 alarm", 7'h18, 32'd0);
        rd_chk("R1 status", 7'h20, 32'd0);
        rd_chk("R1 mask", 7'h24, 32'd0);
        rd_chk("R1 calibration", 7'h0C, 32'h0019_8233);
        rd_chk("R1 control", 7'h40, 32'h0100_0000);
        chk("R1 irq lines", {30'd0, irq_alarm, irq_sec}, 32'd0);
    endtask

    task automatic t_settime;
        wr(7'h00, 32'hFFFF_FFF0);
        rd_chk("R2 readback", 7'h04, 32'hFFFF_FFF0);
        rd_chk("R2 current", 7'h10, 32'hFFFF_FFF0);
    endtask

    task automatic t_calmask;
        wr(7'h08, 32'hFFE0_0005);
        rd_chk("R6 upper bits dropped", 7'h0C, 32'h0000_0005);
    endtask

    task automatic t_prescale;
        wr(7'h08, 32'h0005_0003);      // fraction 5 but bit 20 clear
        wr(7'h00, 32'd10);
        ticks(3);
        rd_chk("R4 tick count", 7'h14, 32'd3);
        rd_chk("R4 no second yet", 7'h10, 32'd10);
        ticks(1);
        rd_chk("R4 second after 4 ticks", 7'h10, 32'd11);
        rd_chk("R4 tick rolled", 7'h14, 32'd0);
        ticks(4);
        rd_chk("R3 increment", 7'h10, 32'd12);
        rd_chk("R8 second status", 7'h20, 32'd1);
    endtask

    task automatic t_wrap;
        wr(7'h00, 32'hFFFF_FFFF);
        ticks(4);
        rd_chk("R3 wrap", 7'h10, 32'd0);
    endtask

    task automatic t_fraction;
        wr(7'h08, 32'h0012_0003);      // enable, N=2, max 3
        wr(7'h00, 32'd0);
        ticks(4);
        rd_chk("R5 long second pending", 7'h10, 32'd0);
        ticks(1);
        rd_chk("R5 first long second", 7'h10, 32'd1);
        ticks(5);
        rd_chk("R5 second long second", 7'h10, 32'd2);
        ticks(4);
        rd_chk("R5 normal second", 7'h10, 32'd3);
        ticks(52);
        rd_chk("R5 window end", 7'h10, 32'd16);
        ticks(4);
        rd_chk("R5 new window long", 7'h10, 32'd16);
        ticks(1);
        rd_chk("R5 new window done", 7'h10, 32'd17);
    endtask

    task automatic t_osc;
        wr(7'h08, 32'h0000_0003);
        wr(7'h00, 32'd7);
        ticks(2);
        wr(7'h40, 32'd0);
        ticks(8);
        rd_chk("R7 tick held", 7'h14, 32'd2);
        rd_chk("R7 secs held", 7'h10, 32'd7);
        rd_chk("R7 control off", 7'h40, 32'd0);
        wr(7'h40, 32'h0100_0000);
        ticks(2);
        rd_chk("R7 resumed", 7'h10, 32'd8);
        ticks(1);
        wr(7'h00, 32'd20);
        rd_chk("R2 tick cleared by load", 7'h14, 32'd0);
    endtask

    task automatic t_irq;
        wr(7'h20, 32'h3);
        rd_chk("R9 cleared", 7'h20, 32'd0);
        ticks(4);
        chk("R11 masked", {31'd0, irq_sec}, 32'd0);
        wr(7'h28, 32'h0);
        rd_chk("R10 zero write", 7'h24, 32'd0);
        wr(7'h28, 32'h1);
        rd_chk("R10 enabled", 7'h24, 32'd1);
        chk("R11 irq_sec high", {31'd0, irq_sec}, 32'd1);
        wr(7'h20, 32'h2);
        rd_chk("R9 other bit kept", 7'h20, 32'd1);
        wr(7'h20, 32'h1);
        rd_chk("R9 bit cleared", 7'h20, 32'd0);
        chk("R11 irq_sec low", {31'd0, irq_sec}, 32'd0);
        wr(7'h2C, 32'h0);
        rd_chk("R10 zero disable", 7'h24, 32'd1);
        wr(7'h2C, 32'h1);
        rd_chk("R10 disabled", 7'h24, 32'd0);
    endtask

    task automatic t_alarm;
        wr(7'h18, 32'd50);
        rd_chk("R8 alarm readback", 7'h18, 32'd50);
        wr(7'h28, 32'h2);
        wr(7'h00, 32'd48);
        wr(7'h20, 32'h3);
        ticks(4);
        rd_chk("R8 no alarm at 49", 7'h20, 32'd1);
        chk("R11 alarm low", {31'd0, irq_alarm}, 32'd0);
        ticks(4);
        rd_chk("R8 alarm at 50", 7'h20, 32'd3);
        chk("R11 alarm high", {31'd0, irq_alarm}, 32'd1);
        wr(7'h20, 32'h2);
        chk("R11 alarm cleared", {31'd0, irq_alarm}, 32'd0);
    endtask

    task automatic t_readzero;
        rd_chk("R12 enable reads 0", 7'h28, 32'd0);
        rd_chk("R12 disable reads 0", 7'h2C, 32'd0);
        rd_chk("R12 unmapped", 7'h30, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_settime();
        t_calmask();
        t_prescale();
        t_wrap();
        t_fraction();
        t_osc();
        t_irq();
        t_alarm();
        t_readzero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule